// File: doc/BRIEF.md
# Triggered Latency Pipeline with Event Derandomizer

The block holds one wide data word per bunch crossing (one crossing per clock) in a circular ring whose depth covers the full trigger latency. The write position advances on every clock and wraps at the ring depth, so the ring always holds the most recent crossings. When an accept trigger arrives, the block works out which ring entry belongs to the crossing that lies a fixed number of crossings (the latency) in the past. It then records that start position together with a window length of one, two or three crossings, which the trigger-time mode input selects.

Recorded triggers wait in a short trigger queue. A copy engine takes them one at a time and moves the chosen consecutive ring words, one per clock, into an event slot of a derandomizing buffer. That buffer has its own write and read slot pointers. Whole events leave the buffer on a clock-driven readout port with a valid/ready handshake. The words of each event come out in crossing order, and the final word of the event is tagged. A trigger that finds no free event slot or no free queue entry is discarded, and a sticky overflow flag records the loss.

Top module: `trig_window_buffer`

## Requirements
- R1: A trigger sampled on the clock edge that stores crossing k (crossings are counted from 0, starting with the first edge after reset release) yields the data of crossings k-LATENCY, k-LATENCY+1, and so on. The ring write position wraps from DEPTH-1 to 0.
- R2: The 2-bit win_mode sampled with the trigger sets the window length: 1 gives one word, 2 gives two words, 3 gives three words, and 0 is treated as one word.
- R3: The words of an event are presented in ascending crossing order. out_last is 1 on the final word of each event and 0 on every other word, and out_last is never 1 without out_valid.
- R4: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values into the next cycle.
- R5: The buffer holds EVT_DEPTH (16) events, counted from trigger acceptance until their last word is read. buf_full is 1 exactly when 16 events are held. A trigger that arrives while buf_full is 1 is discarded and sets overflow.
- R6: overflow stays at 1 until reset.
- R7: The trigger queue holds TQ_DEPTH (4) waiting triggers. The copy engine spends N+1 clocks on an N-word event: one clock to take the entry and N clocks to copy. So five triggers on consecutive clocks with window 3 are all kept, but a sixth one on the next clock finds the queue full, is discarded and sets overflow.
- R8: Events are read out in the order their triggers were accepted.
- R9: After reset, out_valid, out_last, buf_full and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock; one crossing per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing_data | input | DATA_W (240) | Data word of the current crossing |
| trig | input | 1 | Accept trigger strobe for the current crossing |
| win_mode | input | 2 | Window length selector, sampled with trig |
| out_ready | input | 1 | Readout consumer accepts the presented word |
| out_data | output | DATA_W (240) | Presented event word |
| out_valid | output | 1 | out_data holds a word of a completely copied event |
| out_last | output | 1 | Presented word is the last word of its event |
| buf_full | output | 1 | All event slots are taken |
| overflow | output | 1 | Sticky: at least one trigger was discarded |

## Verification
On every cycle, the embedded properties check the following: the ring position wraps, the held word stays stable under back-pressure, out_last occurs only together with out_valid, the event and queue counts stay within bounds, a trigger that meets a full buffer or a full queue raises overflow, and overflow is sticky. Other behaviours show only in the bench's scenarios, because they relate a trigger to words that appear many cycles later. These are the latency arithmetic, the window length for each mode value (including mode 0), ascending crossing order within an event, the order of events, and exactly which trigger of a burst is discarded.

// File: rtl/twb_pkg.sv
package twb_pkg;
   localparam int MODE_W = 2;

   // Window length encoded by the mode input; code 0 falls back to one word.
   function automatic int unsigned mode_len(input logic [MODE_W-1:0] m);
      return (m == '0) ? 1 : int'(m);
   endfunction
endpackage

// File: rtl/twb_ring.sv
module twb_ring #(
   parameter int DATA_W = 240,
   parameter int DEPTH  = 160,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   output logic [AW-1:0]     wr_ptr,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        wr_ptr <= '0;
      else if (wr_ptr == AW'(DEPTH - 1)) wr_ptr <= '0;
      else                               wr_ptr <= wr_ptr + 1'b1;
   end

   assign rd_data = mem[rd_addr];

   // R1: write position wraps at the ring depth
   assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr == AW'(DEPTH - 1)) |=> (wr_ptr == '0));
   assert_ptr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr < AW'(DEPTH));
endmodule

// File: rtl/twb_trig_q.sv
module twb_trig_q #(
   parameter int W  = 10,
   parameter int D  = 4,
   parameter int PW = 2,
   parameter int CW = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] pop_data,
   output logic         empty,
   output logic         full
);
   logic [W-1:0]  slot [D];
   logic [PW-1:0] head, tail;
   logic [CW-1:0] cnt;
   logic          wen, ren;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(D - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty    = (cnt == '0);
   assign full     = (cnt == CW'(D));
   assign wen      = push && !full;
   assign ren      = pop && !empty;
   assign pop_data = slot[head];

   always_ff @(posedge clk) begin
      if (wen) slot[tail] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         cnt  <= '0;
      end else begin
         if (wen) tail <= bump(tail);
         if (ren) head <= bump(head);
         cnt <= cnt + CW'(wen) - CW'(ren);
      end
   end

   // R7: the queue never holds more than its depth
   assert_q_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(D));
   assert_q_no_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      empty |=> (cnt <= 1));
endmodule

// File: rtl/twb_copier.sv
module twb_copier #(
   parameter int DEPTH = 160,
   parameter int AW    = 8,
   parameter int LW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          q_empty,
   input  logic [AW-1:0] q_addr,
   input  logic [LW-1:0] q_len,
   output logic          q_pop,
   output logic [AW-1:0] rd_addr,
   output logic          wr_en,
   output logic [LW-1:0] wr_idx,
   output logic          wr_last,
   output logic [LW-1:0] wr_len
);
   logic          busy;
   logic [AW-1:0] cur_addr;
   logic [LW-1:0] cur_len, cur_idx;

   assign q_pop   = !busy && !q_empty;
   assign rd_addr = cur_addr;
   assign wr_en   = busy;
   assign wr_idx  = cur_idx;
   assign wr_len  = cur_len;
   assign wr_last = busy && (cur_idx == cur_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_addr <= '0;
         cur_len  <= '0;
         cur_idx  <= '0;
      end else if (q_pop) begin
         busy     <= 1'b1;
         cur_addr <= q_addr;
         cur_len  <= q_len;
         cur_idx  <= '0;
      end else if (busy) begin
         cur_addr <= (cur_addr == AW'(DEPTH - 1)) ? '0 : cur_addr + 1'b1;
         cur_idx  <= cur_idx + 1'b1;
         if (wr_last) busy <= 1'b0;
      end
   end

   // R1: every copy address lies inside the ring
   assert_copy_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cur_addr < AW'(DEPTH)));
   // R2: a window is never empty
   assert_copy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cur_len != '0));
endmodule

// File: rtl/twb_derand.sv
module twb_derand #(
   parameter int DATA_W    = 240,
   parameter int EVT_DEPTH = 16,
   parameter int MAX_WIN   = 3,
   parameter int LW        = 2,
   parameter int OW        = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LW-1:0]     wr_idx,
   input  logic              wr_last,
   input  logic [LW-1:0]     wr_len,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_last,
   output logic              rd_done
);
   localparam int SW = $clog2(EVT_DEPTH);
   localparam int NW = EVT_DEPTH * MAX_WIN;
   localparam int FW = $clog2(NW);

   logic [DATA_W-1:0] store [NW];
   logic [LW-1:0]     lens  [EVT_DEPTH];
   logic [SW-1:0]     wslot, rslot;
   logic [LW-1:0]     ridx;
   logic [OW-1:0]     cmpl;
   logic [FW-1:0]     wflat, rflat;
   logic              fire;

   function automatic logic [SW-1:0] next_slot(input logic [SW-1:0] s);
      return (s == SW'(EVT_DEPTH - 1)) ? '0 : s + 1'b1;
   endfunction

   assign wflat     = FW'(int'(wslot) * MAX_WIN + int'(wr_idx));
   assign rflat     = FW'(int'(rslot) * MAX_WIN + int'(ridx));
   assign out_valid = (cmpl != '0);
   assign out_data  = store[rflat];
   assign out_last  = out_valid && (ridx == lens[rslot] - 1'b1);
   assign fire      = out_valid && out_ready;
   assign rd_done   = fire && out_last;

   always_ff @(posedge clk) begin
      if (wr_en)   store[wflat] <= wr_data;
      if (wr_last) lens[wslot]  <= wr_len;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wslot <= '0;
         rslot <= '0;
         ridx  <= '0;
         cmpl  <= '0;
      end else begin
         if (wr_last) wslot <= next_slot(wslot);
         if (fire) begin
            if (out_last) begin
               ridx  <= '0;
               rslot <= next_slot(rslot);
            end else begin
               ridx <= ridx + 1'b1;
            end
         end
         cmpl <= cmpl + OW'(wr_last) - OW'(rd_done);
      end
   end

   // R4: presented word holds under back-pressure
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
   // R3: last tag only on a valid word
   assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
   // R3: the word index never passes the event length
   assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (ridx < lens[rslot]));
endmodule

// File: rtl/trig_window_buffer.sv
module trig_window_buffer #(
   parameter int DATA_W    = 240,
   parameter int DEPTH     = 160,
   parameter int LATENCY   = 100,
   parameter int MAX_WIN   = 3,
   parameter int EVT_DEPTH = 16,
   parameter int TQ_DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] xing_data,
   input  logic              trig,
   input  logic [1:0]        win_mode,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_last,
   output logic              buf_full,
   output logic              overflow
);
   import twb_pkg::*;

   localparam int AW  = $clog2(DEPTH);
   localparam int LW  = $clog2(MAX_WIN + 1);
   localparam int OW  = $clog2(EVT_DEPTH + 1);
   localparam int QW  = AW + LW;
   localparam int QPW = $clog2(TQ_DEPTH);
   localparam int QCW = $clog2(TQ_DEPTH + 1);
   localparam logic [AW:0] BACK = (AW + 1)'(DEPTH - LATENCY);

   generate
      if (LATENCY < MAX_WIN || LATENCY >= DEPTH) begin : g_bad_latency
         $error("LATENCY must lie in [MAX_WIN, DEPTH)");
      end
      if (DEPTH - LATENCY <= TQ_DEPTH * (MAX_WIN + 1) + MAX_WIN + 2) begin : g_bad_margin
         $error("ring too shallow for the trigger queue wait");
      end
      if (MAX_WIN < 1 || MAX_WIN > 3) begin : g_bad_win
         $error("MAX_WIN must be 1..3");
      end
      if (TQ_DEPTH < 2 || EVT_DEPTH < 2) begin : g_bad_depth
         $error("queue and buffer depths must be at least 2");
      end
   endgenerate

   logic [AW-1:0]     wr_ptr, trig_addr, rd_addr;
   logic [AW:0]       back_sum;
   logic [DATA_W-1:0] ring_data;
   logic [LW-1:0]     req_len, q_len, wr_idx, wr_len;
   logic [AW-1:0]     q_addr;
   logic              q_empty, q_full, q_pop, accept;
   logic              wr_en, wr_last, rd_done, overflow_q;
   logic [OW-1:0]     occ;

   // Trigger start position: current write slot minus the latency, modulo DEPTH.
   assign back_sum = {1'b0, wr_ptr} + BACK;
   generate
      if (DEPTH == (1 << AW)) begin : g_pow2_wrap
         assign trig_addr = back_sum[AW-1:0];
      end else begin : g_cmp_wrap
         assign trig_addr = (back_sum >= (AW + 1)'(DEPTH)) ?
                            AW'(back_sum - (AW + 1)'(DEPTH)) : back_sum[AW-1:0];
      end
   endgenerate

   always_comb begin
      int n;
      n = int'(mode_len(win_mode));
      if (n > MAX_WIN) n = MAX_WIN;
      req_len = LW'(n);
   end

   assign buf_full = (occ == OW'(EVT_DEPTH));
   assign accept   = trig && !buf_full && !q_full;
   assign overflow = overflow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ        <= '0;
         overflow_q <= 1'b0;
      end else begin
         occ        <= occ + OW'(accept) - OW'(rd_done);
         overflow_q <= overflow_q | (trig & !accept);
      end
   end

   twb_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ring (
      .clk(clk), .rst_n(rst_n), .wr_data(xing_data), .wr_ptr(wr_ptr),
      .rd_addr(rd_addr), .rd_data(ring_data));

   twb_trig_q #(.W(QW), .D(TQ_DEPTH), .PW(QPW), .CW(QCW)) u_trig_q (
      .clk(clk), .rst_n(rst_n), .push(accept), .push_data({trig_addr, req_len}),
      .pop(q_pop), .pop_data({q_addr, q_len}), .empty(q_empty), .full(q_full));

   twb_copier #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_copier (
      .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_addr(q_addr), .q_len(q_len),
      .q_pop(q_pop), .rd_addr(rd_addr), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_last(wr_last), .wr_len(wr_len));

   twb_derand #(.DATA_W(DATA_W), .EVT_DEPTH(EVT_DEPTH), .MAX_WIN(MAX_WIN),
                .LW(LW), .OW(OW)) u_derand (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_last(wr_last),
      .wr_len(wr_len), .wr_data(ring_data), .out_ready(out_ready),
      .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .rd_done(rd_done));

   // R5: event count bounded; trigger into a full buffer is lost and flagged
   assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OW'(EVT_DEPTH));
   assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && trig) |=> overflow);
   // R7: trigger into a full queue is lost and flagged
   assert_qfull_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && trig) |=> overflow);
   // R6: overflow is sticky
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

// File: tb/trig_window_buffer_bench.sv
module trig_window_buffer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 240;
   localparam int LAT = 100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic          trig = 1'b0;
   logic [1:0]    mode = 2'd1;
   logic          ready = 1'b0;
   logic [DW-1:0] out_data;
   logic          out_valid, out_last, buf_full, overflow;

   int n_checks = 0;
   int n_fail   = 0;
   int xing     = 0;
   bit done     = 1'b0;
   logic [DW:0] expq [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   trig_window_buffer u_trig_window_buffer (
      .clk(clk), .rst_n(rst_n), .xing_data(din), .trig(trig), .win_mode(mode),
      .out_ready(ready), .out_data(out_data), .out_valid(out_valid),
      .out_last(out_last), .buf_full(buf_full), .overflow(overflow));

   function automatic logic [DW-1:0] gen(input int c);
      logic [DW-1:0] v;
      for (int i = 0; i < 8; i++)
         v[i*30 +: 30] = 30'((c * 32'h9E37_79B1) ^ (i * 32'h85EB_CA6B) ^ 32'h1357_2468);
      return v;
   endfunction

   function automatic int win_of(input logic [1:0] m);
      return (m == 2'd0) ? 1 : int'(m);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW:0] act, input logic [DW:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(input bit t, input logic [1:0] m, input bit rdy);
      logic [DW:0] e;
      @(negedge clk);
      din = gen(xing); trig = t; mode = m; ready = rdy;
      #1;
      if (out_valid && ready) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R8", "word with no pending event", {out_last, out_data}, '0);
         end else begin
            e = expq.pop_front();
            chk({out_last, out_data} === e, "R1 R3", "event word", {out_last, out_data}, e);
         end
      end
      xing++;
   endtask

   // Trigger on the current crossing; predicted words queued when it is to be kept.
   task automatic fire_trig(input logic [1:0] m, input bit rdy, input bit kept);
      if (kept)
         for (int j = 0; j < win_of(m); j++)
            expq.push_back({(j == win_of(m) - 1), gen(xing - LAT + j)});
      step(1'b1, m, rdy);
   endtask

   task automatic idle(input int n, input bit rdy);
      for (int i = 0; i < n; i++) step(1'b0, 2'd1, rdy);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; trig = 1'b0; ready = 1'b0;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(out_valid == 1'b0, "R9", "out_valid in reset", DW'(out_valid), '0);
      chk(out_last == 1'b0, "R9", "out_last in reset", DW'(out_last), '0);
      chk(buf_full == 1'b0, "R9", "buf_full in reset", DW'(buf_full), '0);
      chk(overflow == 1'b0, "R9", "overflow in reset", DW'(overflow), '0);
      rst_n = 1'b1; din = gen(0); xing = 1;
      expq.delete();
   endtask

   task automatic drained(input string req);
      chk(expq.size() == 0, req, "pending words after drain", DW'(expq.size()), '0);
      chk(out_valid == 1'b0, req, "out_valid after drain", DW'(out_valid), '0);
   endtask

   initial begin
      logic [DW-1:0] held;
      void'($urandom(32'd20240605));
      do_reset();
      idle(LAT + 5, 1'b1);

      // R2: every mode code, including 0 as one word
      for (int m = 0; m < 4; m++) begin
         fire_trig(2'(m), 1'b1, 1'b1);
         idle(10, 1'b1);
      end
      drained("R2");

      // R4: back-pressure holds the first word of a 3-word event
      fire_trig(2'd3, 1'b0, 1'b1);
      idle(8, 1'b0);
      held = out_data;
      chk(out_valid === 1'b1, "R4", "valid while stalled", DW'(out_valid), 1);
      chk(held === gen(xing - 9 - LAT), "R4", "stalled word", held, gen(xing - 9 - LAT));
      idle(5, 1'b0);
      chk(out_data === held && out_valid, "R4", "word stable under stall", out_data, held);
      chk(out_last === 1'b0, "R3", "first word not last", DW'(out_last), '0);
      idle(10, 1'b1);
      drained("R4");

      // R7: five back-to-back 3-word triggers all kept
      for (int i = 0; i < 5; i++) fire_trig(2'd3, 1'b1, 1'b1);
      idle(40, 1'b1);
      drained("R7");
      chk(overflow == 1'b0, "R7", "no overflow for five", DW'(overflow), '0);

      // R7: sixth back-to-back trigger finds the queue full
      for (int i = 0; i < 6; i++) fire_trig(2'd3, 1'b1, i < 5);
      idle(40, 1'b1);
      drained("R7");
      chk(overflow == 1'b1, "R7", "overflow on sixth", DW'(overflow), 1);
      idle(20, 1'b1);
      chk(overflow == 1'b1, "R6", "overflow sticky", DW'(overflow), 1);

      // R6: reset clears the flag
      do_reset();
      chk(overflow == 1'b0, "R6", "overflow after reset", DW'(overflow), '0);
      idle(LAT + 5, 1'b0);

      // R5: sixteen held events fill the buffer; the next trigger is lost
      for (int i = 0; i < 16; i++) begin
         fire_trig(2'(1 + (i % 3)), 1'b0, 1'b1);
         idle(5, 1'b0);
         if (i == 14) chk(buf_full == 1'b0, "R5", "not full at 15", DW'(buf_full), '0);
      end
      chk(buf_full == 1'b1, "R5", "full at 16", DW'(buf_full), 1);
      chk(overflow == 1'b0, "R5", "no overflow yet", DW'(overflow), '0);
      fire_trig(2'd2, 1'b0, 1'b0);
      idle(1, 1'b0);
      chk(overflow == 1'b1, "R5", "overflow on 17th", DW'(overflow), 1);
      idle(60, 1'b1);
      drained("R5");
      chk(buf_full == 1'b0, "R5", "full cleared after drain", DW'(buf_full), '0);

      // R8 R1 R2: random modes, gaps and readout stalls
      do_reset();
      idle(LAT + 5, 1'b1);
      for (int e = 0; e < 80; e++) begin
         fire_trig(2'($urandom % 4), ($urandom % 4) != 0, 1'b1);
         for (int g = 0; g < 8 + int'($urandom % 5); g++)
            step(1'b0, 2'd1, ($urandom % 4) != 0);
      end
      idle(60, 1'b1);
      drained("R8");
      chk(overflow == 1'b0, "R8", "no loss in random run", DW'(overflow), '0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R9 watchdog: actual=hung expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule